// File: doc/BRIEF.md
# Host-Side Single-Wire Memory Sequencer

This block sits on the processor side of a small nonvolatile byte memory. The memory is reached only through ordinary bus strobes (chip enable, output enable, write enable) and one data bit. The engine takes a byte-level request and breaks it into a stream of single-bit bus cycles. A request either reads a run of bytes starting at an address, or writes one to eight bytes into a single eight-byte page. Each bus cycle lasts a fixed number of clocks, and the widths of its low and high phases come from two configuration inputs.

Every accepted request opens with a reset pattern, followed by a sixteen-bit address frame. A read then clocks in data bits and hands back whole bytes. A write shifts out its data bits and issues the start-programming pattern. It then polls the data line until the memory reports that programming is finished. The poll count is bounded. When the bound runs out, the engine flags a fault and sends a further reset pattern to leave the memory idle. A write that would spill past its page is refused before any bus activity.

Top module: `swm_sequencer`

## Requirements
- R1: After reset the engine is idle: `req_ready` is 1, `ce_n`, `oe_n` and `we_n` are 1, `dq_oe` is 0, and `done`, `err_page` and `fault` are 0.
- R2: Every accepted request starts with three bus cycles: a read, a write of 0, and a read.
- R3: The reset pattern is followed by 16 write cycles carrying `{7'b0, req_addr}`, most significant bit first.
- R4: A read request of L bytes issues 8·L read cycles after the address frame and no further address cycles. Each group of 8 sampled bits, first sample in bit 7, is presented on `rd_data` with a one-clock `rd_valid`.
- R5: A write request of L bytes sends 8·L write cycles after the address frame. Byte k is `req_wdata[8k+7:8k]`, with byte 0 first and each byte MSB first. These are followed by a read, a write of 1, and a read.
- R6: After the start pattern, the engine issues read cycles until one samples 1, then completes with `fault` = 0.
- R7: If POLL_MAX consecutive poll reads all sample 0, the engine sets `fault` and issues a read, a write of 0, and a read before completing.
- R8: A request is refused with `err_page` = 1 and no bus cycle in either of these cases:
  - its length is 0;
  - it is a write for which (address mod 8) + length exceeds 8.
- R9: Within a cycle, the strobes stay low for exactly max(`cfg_low`,1) clocks. All strobes then stay high for at least max(`cfg_high`,1) clocks before the next cycle. Write data stays driven and unchanged from the falling edge until after the rising edge.
- R10: Rules on the bus lines:
  - `oe_n` and `we_n` are never low together;
  - neither is low while `ce_n` is high;
  - `dq_oe` is never 1 while `oe_n` is low.
- R11: `done` is a single-clock pulse per request. `err_page` and `fault` keep their value after `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_low | input | CNT_W | Strobe low width in clocks (0 treated as 1) |
| cfg_high | input | CNT_W | Minimum recovery width in clocks (0 treated as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this clock if valid |
| req_write | input | 1 | 1 = page write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Byte count |
| req_wdata | input | 8·PAGE_BYTES | Write bytes, byte k in bits 8k+7:8k |
| rd_valid | output | 1 | One-clock strobe for a read byte |
| rd_data | output | 8 | Assembled read byte |
| done | output | 1 | Request finished (one clock) |
| busy | output | 1 | Request in progress |
| err_page | output | 1 | Last request refused |
| fault | output | 1 | Last write timed out while polling |
| ce_n | output | 1 | Chip enable strobe, active low |
| oe_n | output | 1 | Output enable strobe, active low |
| we_n | output | 1 | Write enable strobe, active low |
| dq_out | output | 1 | Data bit driven to the memory |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 1 | Data bit sampled from the memory |

## Verification
The hardest state to reach is the poll timeout. Reaching it needs a full write, the start pattern, and then an unbroken run of busy replies long enough to exhaust the poll bound. The bench reaches it by answering every read cycle from a reply table indexed by the cycle's position within the request. That table holds the data line at 0 for a chosen number of poll reads. The poll bound is made small through the parameter, so the timeout and the recovery pattern that follows it occur in a short run. The same table supplies known byte patterns for reads, so the bench can check the MSB-first assembly bit by bit.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int unsigned FRAME_BITS = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_ADDR, S_WDATA, S_RDATA, S_PGM, S_POLL, S_RECOV, S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    C_IDLE, C_LOW, C_HIGH
  } cyc_state_t;
endpackage

// File: rtl/swm_cycle.sv
module swm_cycle
  import swm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             is_wr,
  input  logic             wbit,
  input  logic [CNT_W-1:0] t_low,
  input  logic [CNT_W-1:0] t_high,
  input  logic             dq_in,
  output logic             ready,
  output logic             done,
  output logic             rbit,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_out,
  output logic             dq_oe
);
  cyc_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] low_m1;
  logic [CNT_W-1:0] high_m1;

  assign low_m1  = (t_low  == '0) ? '0 : t_low  - CNT_W'(1);
  assign high_m1 = (t_high == '0) ? '0 : t_high - CNT_W'(1);
  assign ready   = (st == C_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= C_IDLE;
      cnt    <= '0;
      ce_n   <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      dq_out <= 1'b0;
      dq_oe  <= 1'b0;
      done   <= 1'b0;
      rbit   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        C_IDLE: begin
          if (go) begin
            st     <= C_LOW;
            cnt    <= low_m1;
            ce_n   <= 1'b0;
            oe_n   <= is_wr;
            we_n   <= !is_wr;
            dq_oe  <= is_wr;
            dq_out <= is_wr & wbit;
          end
        end
        C_LOW: begin
          if (cnt == '0) begin
            rbit <= dq_in;
            ce_n <= 1'b1;
            oe_n <= 1'b1;
            we_n <= 1'b1;
            cnt  <= high_m1;
            st   <= C_HIGH;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        C_HIGH: begin
          if (cnt == '0) begin
            dq_oe <= 1'b0;
            done  <= 1'b1;
            st    <= C_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R10: the two strobes are mutually exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));
  // R10: no strobe without chip enable
  p_strobe_needs_ce_r10: assert property (@(posedge clk) disable iff (rst)
    (!oe_n || !we_n) |-> !ce_n);
  // R10: never drive the line while the memory may drive it
  p_no_drive_on_read_r10: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);
  // R9: write data held through the rising edge of the strobe
  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && !we_n) |=> (dq_oe && $stable(dq_out)));
  // R9: a new cycle only starts from the idle phase
  p_go_idle_r9: assert property (@(posedge clk) disable iff (rst)
    go |-> ready);
endmodule

// File: rtl/swm_pagechk.sv
module swm_pagechk #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned PAGE_BYTES = 8
) (
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              reject
);
  localparam int unsigned OFS_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

  logic [LEN_W:0] end_pos;

  always_comb begin
    end_pos = {1'b0, len} + (LEN_W+1)'(addr[OFS_W-1:0]);
    reject  = (len == '0) || (is_write && (end_pos > (LEN_W+1)'(PAGE_BYTES)));
  end
endmodule

// File: rtl/swm_rxbyte.sv
module swm_rxbyte (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       shift_en,
  input  logic       bit_in,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  logic [6:0] sh;
  logic [2:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      cnt        <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (shift_en) begin
        sh  <= {sh[5:0], bit_in};
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          byte_data  <= {sh, bit_in};
          byte_valid <= 1'b1;
        end
      end
    end
  end

  // R4: a byte appears only right after a sampled bit
  p_byte_after_shift_r4: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(shift_en));
endmodule

// File: rtl/swm_ctrl.sv
module swm_ctrl
  import swm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned POLL_MAX   = 4096
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [PAGE_BYTES*8-1:0] req_wdata,
  input  logic                    reject,
  output logic                    req_ready,
  output logic                    busy,
  output logic                    done,
  output logic                    err_page,
  output logic                    fault,
  output logic                    cyc_go,
  output logic                    cyc_wr,
  output logic                    cyc_bit,
  input  logic                    cyc_ready,
  input  logic                    cyc_done,
  input  logic                    cyc_rbit,
  output logic                    rx_clear,
  output logic                    rx_shift
);
  localparam int unsigned DATA_W = PAGE_BYTES * 8;
  localparam int unsigned IDX_W  = ($clog2(DATA_W) + 1 > 5) ? $clog2(DATA_W) + 1 : 5;
  localparam int unsigned POLL_W = $clog2(POLL_MAX + 1);

  seq_state_t            st;
  logic                  inflight;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      last_bit;
  logic [LEN_W-1:0]      bytes_left;
  logic [FRAME_BITS-1:0] frame;
  logic [DATA_W-1:0]     wstream;
  logic [DATA_W-1:0]     wbuf;
  logic                  op_write;
  logic [POLL_W-1:0]     polls;
  logic                  cur_wr;
  logic                  cur_bit;
  logic                  active;
  logic                  accept;

  always_comb begin
    wstream = '0;
    for (int k = 0; k < PAGE_BYTES; k++) begin
      wstream[DATA_W-1-8*k -: 8] = req_wdata[8*k +: 8];
    end
  end

  always_comb begin
    cur_wr  = 1'b0;
    cur_bit = 1'b0;
    case (st)
      S_RST, S_RECOV: cur_wr = (idx == IDX_W'(1));
      S_PGM: begin
        cur_wr  = (idx == IDX_W'(1));
        cur_bit = 1'b1;
      end
      S_ADDR: begin
        cur_wr  = 1'b1;
        cur_bit = frame[FRAME_BITS-1];
      end
      S_WDATA: begin
        cur_wr  = 1'b1;
        cur_bit = wbuf[DATA_W-1];
      end
      default: ;
    endcase
  end

  assign active    = (st != S_IDLE) && (st != S_DONE);
  assign req_ready = (st == S_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_ready && req_valid;
  assign rx_clear  = accept;
  assign rx_shift  = cyc_done && inflight && (st == S_RDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      inflight   <= 1'b0;
      idx        <= '0;
      last_bit   <= '0;
      bytes_left <= '0;
      frame      <= '0;
      wbuf       <= '0;
      op_write   <= 1'b0;
      polls      <= '0;
      done       <= 1'b0;
      err_page   <= 1'b0;
      fault      <= 1'b0;
      cyc_go     <= 1'b0;
      cyc_wr     <= 1'b0;
      cyc_bit    <= 1'b0;
    end else begin
      done   <= 1'b0;
      cyc_go <= 1'b0;

      if (active && !inflight && !cyc_go && cyc_ready) begin
        cyc_go   <= 1'b1;
        cyc_wr   <= cur_wr;
        cyc_bit  <= cur_bit;
        inflight <= 1'b1;
      end

      case (st)
        S_IDLE: begin
          if (req_valid) begin
            err_page <= reject;
            fault    <= 1'b0;
            idx      <= '0;
            if (reject) begin
              st <= S_DONE;
            end else begin
              st         <= S_RST;
              op_write   <= req_write;
              frame      <= FRAME_BITS'(req_addr);
              wbuf       <= wstream;
              bytes_left <= req_len;
              last_bit   <= IDX_W'({req_len, 3'b000} - 1);
            end
          end
        end
        S_DONE: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: begin
          if (cyc_done && inflight) begin
            inflight <= 1'b0;
            case (st)
              S_RST: begin
                if (idx == IDX_W'(2)) begin
                  idx <= '0;
                  st  <= S_ADDR;
                end else idx <= idx + IDX_W'(1);
              end
              S_ADDR: begin
                frame <= frame << 1;
                if (idx == IDX_W'(FRAME_BITS - 1)) begin
                  idx <= '0;
                  st  <= op_write ? S_WDATA : S_RDATA;
                end else idx <= idx + IDX_W'(1);
              end
              S_WDATA: begin
                wbuf <= wbuf << 1;
                if (idx == last_bit) begin
                  idx <= '0;
                  st  <= S_PGM;
                end else idx <= idx + IDX_W'(1);
              end
              S_RDATA: begin
                if (idx == IDX_W'(7)) begin
                  idx <= '0;
                  if (bytes_left == LEN_W'(1)) st <= S_DONE;
                  else bytes_left <= bytes_left - LEN_W'(1);
                end else idx <= idx + IDX_W'(1);
              end
              S_PGM: begin
                if (idx == IDX_W'(2)) begin
                  idx   <= '0;
                  polls <= '0;
                  st    <= S_POLL;
                end else idx <= idx + IDX_W'(1);
              end
              S_POLL: begin
                if (cyc_rbit) begin
                  st <= S_DONE;
                end else if (polls == POLL_W'(POLL_MAX - 1)) begin
                  fault <= 1'b1;
                  idx   <= '0;
                  st    <= S_RECOV;
                end else polls <= polls + POLL_W'(1);
              end
              S_RECOV: begin
                if (idx == IDX_W'(2)) st <= S_DONE;
                else idx <= idx + IDX_W'(1);
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R11: completion is a single-clock pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: a refused request goes straight to completion without a bus cycle
  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && reject) |=> (st == S_DONE && !cyc_go));
  // R7: a fault is raised only on the way into the recovery pattern
  p_fault_recov_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> (st == S_RECOV));
  // R11: flags hold while idle with no new request
  p_flags_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !req_valid) |=> ($stable(err_page) && $stable(fault)));
endmodule

// File: rtl/swm_sequencer.sv
module swm_sequencer #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned POLL_MAX   = 4096,
  localparam int unsigned DATA_W    = PAGE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_low,
  input  logic [CNT_W-1:0]  cfg_high,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              busy,
  output logic              err_page,
  output logic              fault,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_out,
  output logic              dq_oe,
  input  logic              dq_in
);
  logic reject;
  logic cyc_go, cyc_wr, cyc_bit, cyc_ready, cyc_done, cyc_rbit;
  logic rx_clear, rx_shift;

  swm_pagechk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_pagechk (
    .is_write(req_write), .addr(req_addr), .len(req_len), .reject(reject)
  );

  swm_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .POLL_MAX(POLL_MAX)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .reject(reject),
    .req_ready(req_ready), .busy(busy), .done(done),
    .err_page(err_page), .fault(fault),
    .cyc_go(cyc_go), .cyc_wr(cyc_wr), .cyc_bit(cyc_bit),
    .cyc_ready(cyc_ready), .cyc_done(cyc_done), .cyc_rbit(cyc_rbit),
    .rx_clear(rx_clear), .rx_shift(rx_shift)
  );

  swm_cycle #(
    .CNT_W(CNT_W)
  ) u_cycle (
    .clk(clk), .rst(rst), .go(cyc_go), .is_wr(cyc_wr), .wbit(cyc_bit),
    .t_low(cfg_low), .t_high(cfg_high), .dq_in(dq_in),
    .ready(cyc_ready), .done(cyc_done), .rbit(cyc_rbit),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  swm_rxbyte u_rxbyte (
    .clk(clk), .rst(rst), .clear(rx_clear), .shift_en(rx_shift),
    .bit_in(cyc_rbit), .byte_valid(rd_valid), .byte_data(rd_data)
  );
endmodule

// File: tb/swm_sequencer_bench.sv
module swm_sequencer_bench;
  localparam int PMAX = 16;
  localparam int LOGN = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_low = 8'd2, cfg_high = 8'd2;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rd_valid, done, busy, err_page, fault;
  logic [7:0]  rd_data;
  logic        ce_n, oe_n, we_n, dq_out, dq_oe;
  logic        dq_in = 1'b1;

  swm_sequencer #(.POLL_MAX(PMAX)) u_swm_sequencer (
    .clk(clk), .rst(rst), .cfg_low(cfg_low), .cfg_high(cfg_high),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .busy(busy),
    .err_page(err_page), .fault(fault), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit log_kind [LOGN];
  bit log_bit  [LOGN];
  bit exp_kind [LOGN];
  bit exp_bit  [LOGN];
  int log_n, exp_n, rd_k, rx_n, done_cnt, bus_bad, tim_bad;
  int low_run, high_run;
  bit prev_ce = 1'b1, seen_rise, cur_wr, cur_b;
  logic [7:0] rx [64];
  logic [7:0] pat [16];
  bit mode_wr;
  int busy_n;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit rd_value(input int k);
    int j;
    if (mode_wr) begin
      if (k < 4) return 1'b1;
      return ((k - 4) < busy_n) ? 1'b0 : 1'b1;
    end
    if (k < 2) return 1'b1;
    j = k - 2;
    return pat[j / 8][7 - (j % 8)];
  endfunction

  function automatic int eff(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      prev_ce = 1'b1;
    end else begin
      if (!oe_n && !we_n) bus_bad++;
      if ((!oe_n || !we_n) && ce_n) bus_bad++;
      if (dq_oe && !oe_n) bus_bad++;
      if (prev_ce && !ce_n) begin
        if (seen_rise && high_run < eff(cfg_high)) tim_bad++;
        cur_wr = !we_n;
        cur_b  = dq_out;
        if (cur_wr && !dq_oe) bus_bad++;
        if (log_n < LOGN) begin
          log_kind[log_n] = cur_wr;
          log_bit[log_n]  = cur_wr ? dq_out : 1'b0;
        end
        log_n++;
        if (!oe_n) begin
          dq_in = rd_value(rd_k);
          rd_k++;
        end
        low_run = 1;
      end else if (!ce_n) begin
        low_run++;
        if (cur_wr && (dq_out != cur_b || !dq_oe)) tim_bad++;
      end else if (!prev_ce && ce_n) begin
        if (low_run != eff(cfg_low)) tim_bad++;
        if (cur_wr && (dq_out != cur_b || !dq_oe)) tim_bad++;
        high_run  = 1;
        seen_rise = 1'b1;
      end else begin
        high_run++;
      end
      prev_ce = ce_n;
      if (rd_valid && rx_n < 64) begin
        rx[rx_n] = rd_data;
        rx_n++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic exp_push(input bit k, input bit b);
    exp_kind[exp_n] = k;
    exp_bit[exp_n]  = b;
    exp_n++;
  endtask

  task automatic exp_pattern(input bit b);
    exp_push(1'b0, 1'b0);
    exp_push(1'b1, b);
    exp_push(1'b0, 1'b0);
  endtask

  task automatic exp_addr(input logic [8:0] a);
    logic [15:0] f;
    f = {7'b0, a};
    for (int i = 15; i >= 0; i--) exp_push(1'b1, f[i]);
  endtask

  task automatic cmp_range(input int lo, input int hi, input string tag,
                           input string what);
    int bad;
    bad = -1;
    for (int i = lo; i < hi; i++) begin
      if (bad < 0 && (i >= log_n || log_kind[i] != exp_kind[i] ||
                      log_bit[i] != exp_bit[i])) bad = i;
    end
    if (bad < 0) check(1'b1, tag, what, 0, 0);
    else if (bad >= log_n) check(1'b0, tag, {what, " missing cycle"}, log_n, bad + 1);
    else check(1'b0, tag, what, 2 * log_kind[bad] + log_bit[bad],
               2 * exp_kind[bad] + exp_bit[bad]);
  endtask

  task automatic run_op(input bit wr, input logic [8:0] a, input logic [7:0] l,
                        input logic [63:0] d);
    log_n = 0; exp_n = 0; rd_k = 0; rx_n = 0; done_cnt = 0;
    bus_bad = 0; tim_bad = 0; seen_rise = 1'b0; mode_wr = wr;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = l; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    do @(negedge clk); while (!done);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check({ce_n, oe_n, we_n} == 3'b111, "R1", "strobes idle", {ce_n, oe_n, we_n}, 7);
    check(dq_oe == 1'b0, "R1", "line not driven", dq_oe, 0);
    check({done, err_page, fault} == 3'b000, "R1", "status clear",
          {done, err_page, fault}, 0);
  endtask

  task automatic t_read(input logic [8:0] a, input int l,
                        input logic [7:0] tl, input logic [7:0] th);
    cfg_low = tl; cfg_high = th;
    for (int i = 0; i < 16; i++) pat[i] = 8'(8'h3C + i * 8'h47);
    run_op(1'b0, a, 8'(l), 64'h0);
    exp_pattern(1'b0);
    exp_addr(a);
    for (int i = 0; i < 8 * l; i++) exp_push(1'b0, 1'b0);
    cmp_range(0, 3, "R2", "reset pattern (read)");
    cmp_range(3, 19, "R3", "address frame (read)");
    cmp_range(19, exp_n, "R4", "data read cycles");
    check(log_n == exp_n, "R4", "read cycle count", log_n, exp_n);
    check(rx_n == l, "R4", "bytes returned", rx_n, l);
    for (int i = 0; i < l && i < rx_n; i++)
      check(rx[i] == pat[i], "R4", "byte value", rx[i], pat[i]);
    check(tim_bad == 0, "R9", "strobe widths (read)", tim_bad, 0);
    check(bus_bad == 0, "R10", "bus rules (read)", bus_bad, 0);
    check(done_cnt == 1, "R11", "done pulse count", done_cnt, 1);
    check(err_page == 0 && fault == 0, "R11", "flags after read", {err_page, fault}, 0);
  endtask

  task automatic t_write(input logic [8:0] a, input int l, input logic [63:0] d,
                         input int bn, input logic [7:0] tl, input logic [7:0] th);
    int base;
    cfg_low = tl; cfg_high = th; busy_n = bn;
    run_op(1'b1, a, 8'(l), d);
    exp_pattern(1'b0);
    exp_addr(a);
    for (int k = 0; k < l; k++)
      for (int b = 7; b >= 0; b--) exp_push(1'b1, d[8 * k + b]);
    exp_pattern(1'b1);
    base = exp_n;
    if (bn < PMAX) begin
      for (int i = 0; i <= bn; i++) exp_push(1'b0, 1'b0);
    end else begin
      for (int i = 0; i < PMAX; i++) exp_push(1'b0, 1'b0);
      exp_pattern(1'b0);
    end
    cmp_range(0, 3, "R2", "reset pattern (write)");
    cmp_range(3, 19, "R3", "address frame (write)");
    cmp_range(19, 19 + 8 * l, "R5", "data bits");
    cmp_range(19 + 8 * l, base, "R5", "start pattern");
    if (bn < PMAX) begin
      cmp_range(base, exp_n, "R6", "poll reads");
      check(log_n == exp_n, "R6", "poll ends on ready", log_n, exp_n);
      check(fault == 0, "R6", "no fault", fault, 0);
    end else begin
      cmp_range(base, base + PMAX, "R7", "bounded polls");
      cmp_range(base + PMAX, exp_n, "R7", "recovery pattern");
      check(log_n == exp_n, "R7", "timeout cycle count", log_n, exp_n);
      check(fault == 1, "R7", "fault raised", fault, 1);
      repeat (4) @(negedge clk);
      check(fault == 1, "R11", "fault held", fault, 1);
    end
    check(tim_bad == 0, "R9", "strobe widths (write)", tim_bad, 0);
    check(bus_bad == 0, "R10", "bus rules (write)", bus_bad, 0);
    check(done_cnt == 1, "R11", "done pulse count", done_cnt, 1);
  endtask

  task automatic t_reject(input bit wr, input logic [8:0] a, input int l);
    run_op(wr, a, 8'(l), 64'hFFFF_0000_FFFF_0000);
    check(log_n == 0, "R8", "no bus cycle on refusal", log_n, 0);
    check(err_page == 1, "R8", "refusal flag", err_page, 1);
    repeat (4) @(negedge clk);
    check(err_page == 1, "R11", "refusal flag held", err_page, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(9'h1A5, 3, 8'd3, 8'd5);
    t_read(9'h1FF, 2, 8'd0, 8'd0);
    t_write(9'h0A8, 8, 64'hA5C3_0F81_7E24_D9B6, 5, 8'd3, 8'd5);
    t_write(9'h0D5, 3, 64'h0000_0000_0055_E71A, 0, 8'd1, 8'd2);
    t_reject(1'b1, 9'h0D6, 3);
    t_reject(1'b1, 9'h040, 9);
    t_reject(1'b1, 9'h040, 0);
    t_reject(1'b0, 9'h123, 0);
    t_write(9'h010, 1, 64'h0000_0000_0000_0096, 1000, 8'd2, 8'd1);
    t_read(9'h000, 1, 8'd2, 8'd2);
    check(err_page == 0 && fault == 0, "R11", "flags cleared by new request",
          {err_page, fault}, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule